// File: doc/BRIEF.md
# Cartridge PRG Bank Controller

This block sits on the program bus of an 8-bit 6502-family console cartridge. It watches CPU writes in a small register window just above $5000. From them it keeps a four-bit low bank number, a two-bit high bank number and a two-bit mode word. It combines these into the six upper address lines (A20..A15) of a 32 KiB program-ROM window that the CPU sees at $8000-$FFFF. It also gates an 8 KiB unbanked work RAM that answers at $6000-$7FFF.

Two mode bits shape the result:
- One picks whether data bits 0 and 1 trade places while a bank register is loaded. The exchange happens only at the moment of the load and never on the output side, so values already held keep their bits when this mode bit changes later.
- The other either passes the two lowest bank bits through or ties A15 and A16 high. Because every register clears on reset, the console starts in 32 KiB bank 3.

The bus strobe is sampled with a fast system clock. A register load happens on the clock edge that first sees M2 low after it was high while R/W is low. The address and data lines must be stable around that edge.

Top module: `cart_prg_banker`

## Requirements
- R1: After reset, all held state is zero and `prg_bank` (bit 0 = A15, bit 5 = A20) reads 6'b000011, i.e. 32 KiB bank 3.
- R2: A write to any address whose value ANDed with $FF00 equals $5000 loads the low bank. Its four bits drive `prg_bank[3:0]` (A18..A15) when the pass-through mode bit is set.
- R3: A write to any address whose value ANDed with $FB00 equals $5100 loads the high bank, so both $51xx and $55xx hit it. Its two bits drive `prg_bank[5:4]` (A20..A19).
- R4: Mode data bit 0 controls bank loads. When it is 0, written data bits 0 and 1 are exchanged before the low or high bank is loaded. When it is 1, they are loaded unchanged.
- R5: A write to $53xx (mask $FF00) loads data bits 0 and 2 into the mode word without any exchange, whatever the current mode.
- R6: While mode data bit 2 is 0, `prg_bank[1:0]` is 2'b11. While it is 1, `prg_bank[1:0]` follows low bank bits 1:0.
- R7: Writing the mode word never changes the values already held in the low or high bank.
- R8: State changes only on the clock edge that first sees M2 low after high with R/W low and a decoded address. Read cycles to register addresses, and writes to $52xx, $54xx or any other address, leave `prg_bank` unchanged.
- R9: `rom_ce_n` is low exactly when R/W is high and A15 is 1.
- R10: `ram_ce_n` is low exactly when A15..A13 = 3'b011 and M2 is high. `ram_oe_n` also needs R/W high, and `ram_we_n` also needs R/W low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the CPU bus |
| rst_n | input | 1 | Active-low reset, clears all registers |
| cpu_addr | input | 16 | CPU address bus |
| cpu_data | input | 8 | CPU data bus (write data) |
| cpu_rw | input | 1 | CPU R/W, 1 = read, 0 = write |
| cpu_m2 | input | 1 | CPU M2 phase strobe |
| prg_bank | output | 6 | ROM address lines A20..A15, bit 0 = A15 |
| rom_ce_n | output | 1 | Program ROM enable, active low |
| ram_ce_n | output | 1 | Work RAM chip enable, active low |
| ram_oe_n | output | 1 | Work RAM output enable, active low |
| ram_we_n | output | 1 | Work RAM write enable, active low |

## Verification
Two functions can meet in one capture cycle: a bank-register load, and the bit-exchange decision taken from a mode word that was itself written on the directly preceding bus cycle. The sweep writes every mode value and then, back to back, every low and high bank value, with the high bank reached alternately through both of its aliases. Each resulting `prg_bank` is judged against the exchange and the A15/A16 forcing computed arithmetically in the bench. A second pair is the mode rewrite that flips the exchange bit while bank data is held. That case is judged by checking that `prg_bank` keeps its previous bits.

// File: rtl/cart_pkg.sv
package cart_pkg;

   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_LOW  = 2'd1,
      SEL_HIGH = 2'd2,
      SEL_MODE = 2'd3
   } reg_sel_e;

   typedef struct packed {
      logic pass_low;   // 1: A16/A15 from low bank, 0: forced high
      logic keep_bits;  // mode data bit 0 as written
   } mode_t;

endpackage

// File: rtl/cart_wr_decode.sv
module cart_wr_decode
   import cart_pkg::*;
#(
   parameter int          ADDR_W    = 16,
   parameter logic [15:0] LOW_BASE  = 16'h5000,
   parameter logic [15:0] LOW_MASK  = 16'hFF00,
   parameter logic [15:0] HIGH_BASE = 16'h5100,
   parameter logic [15:0] HIGH_MASK = 16'hFB00,
   parameter logic [15:0] MODE_BASE = 16'h5300,
   parameter logic [15:0] MODE_MASK = 16'hFF00
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              rw,
   input  logic              m2,
   output logic              wr_stb,
   output reg_sel_e          sel
);

   generate
      if (ADDR_W != 16) begin : g_bad_addr
         $error("cart_wr_decode: ADDR_W must be 16");
      end
   endgenerate

   logic m2_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) m2_q <= 1'b0;
      else        m2_q <= m2;
   end

   assign wr_stb = m2_q & ~m2 & ~rw;

   logic hit_low, hit_high, hit_mode;
   assign hit_low  = (addr & LOW_MASK)  == LOW_BASE;
   assign hit_high = (addr & HIGH_MASK) == HIGH_BASE;
   assign hit_mode = (addr & MODE_MASK) == MODE_BASE;

   always_comb begin
      if (hit_low)       sel = SEL_LOW;
      else if (hit_high) sel = SEL_HIGH;
      else if (hit_mode) sel = SEL_MODE;
      else               sel = SEL_NONE;
   end

   always_comb begin
      assert ($countones({hit_low, hit_high, hit_mode}) <= 1)
         else $error("AST_SEL_ONEHOT");  // R8
   end

endmodule

// File: rtl/cart_bank_regs.sv
module cart_bank_regs
   import cart_pkg::*;
#(
   parameter int LOW_W         = 4,
   parameter int HIGH_W        = 2,
   parameter bit SWAP_ON_CLEAR = 1'b1,
   localparam int REG_W        = (LOW_W > 3) ? LOW_W : 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_stb,
   input  reg_sel_e          sel,
   input  logic [REG_W-1:0]  data,
   output logic [LOW_W-1:0]  low_q,
   output logic [HIGH_W-1:0] high_q,
   output mode_t             mode_q
);

   generate
      if (LOW_W < 2) begin : g_bad_low
         $error("cart_bank_regs: LOW_W must be at least 2");
      end
      if (HIGH_W < 1 || HIGH_W > REG_W) begin : g_bad_high
         $error("cart_bank_regs: HIGH_W out of range");
      end
   endgenerate

   logic swap_now;
   generate
      if (SWAP_ON_CLEAR) begin : g_swap_clear
         assign swap_now = ~mode_q.keep_bits;
      end else begin : g_swap_set
         assign swap_now = mode_q.keep_bits;
      end
   endgenerate

   logic [REG_W-1:0] wdata;
   assign wdata = swap_now ? {data[REG_W-1:2], data[0], data[1]} : data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_q  <= '0;
         high_q <= '0;
         mode_q <= '0;
      end else if (wr_stb) begin
         unique case (sel)
            SEL_LOW:  low_q  <= wdata[LOW_W-1:0];
            SEL_HIGH: high_q <= wdata[HIGH_W-1:0];
            SEL_MODE: mode_q <= '{pass_low: data[2], keep_bits: data[0]};
            default: ;
         endcase
      end
   end

   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_stb |=> $stable(low_q) && $stable(high_q) && $stable(mode_q))
      else $error("AST_HOLD_IDLE");  // R8

   AST_MODE_RAW: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && sel == SEL_MODE) |=> (mode_q.pass_low == $past(data[2]) && mode_q.keep_bits == $past(data[0])))
      else $error("AST_MODE_RAW");  // R5

   AST_MODE_KEEPS_BANKS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && sel == SEL_MODE) |=> $stable(low_q) && $stable(high_q))
      else $error("AST_MODE_KEEPS_BANKS");  // R7

   AST_LOW_EXCHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && sel == SEL_LOW && (mode_q.keep_bits != SWAP_ON_CLEAR)) |=> low_q[1:0] == {$past(data[0]), $past(data[1])})
      else $error("AST_LOW_EXCHANGE");  // R4

   AST_LOW_STRAIGHT: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && sel == SEL_LOW && (mode_q.keep_bits == SWAP_ON_CLEAR)) |=> low_q[1:0] == $past(data[1:0]))
      else $error("AST_LOW_STRAIGHT");  // R4

endmodule

// File: rtl/cart_mem_map.sv
module cart_mem_map
   import cart_pkg::*;
#(
   parameter int         LOW_W    = 4,
   parameter int         HIGH_W   = 2,
   parameter logic [2:0] RAM_TOP3 = 3'b011,
   localparam int        BANK_W   = LOW_W + HIGH_W
) (
   input  logic [LOW_W-1:0]  low_q,
   input  logic [HIGH_W-1:0] high_q,
   input  mode_t             mode_q,
   input  logic [2:0]        addr_top,
   input  logic              rw,
   input  logic              m2,
   output logic [BANK_W-1:0] prg_bank,
   output logic              rom_ce_n,
   output logic              ram_ce_n,
   output logic              ram_oe_n,
   output logic              ram_we_n
);

   logic [1:0] low_pair;
   assign low_pair = mode_q.pass_low ? low_q[1:0] : 2'b11;

   generate
      if (LOW_W > 2) begin : g_wide_low
         assign prg_bank = {high_q, low_q[LOW_W-1:2], low_pair};
      end else begin : g_narrow_low
         assign prg_bank = {high_q, low_pair};
      end
   endgenerate

   logic ram_hit;
   assign ram_hit  = (addr_top == RAM_TOP3);
   assign rom_ce_n = ~(addr_top[2] & rw);
   assign ram_ce_n = ~(ram_hit & m2);
   assign ram_oe_n = ~(ram_hit & m2 & rw);
   assign ram_we_n = ~(ram_hit & m2 & ~rw);

endmodule

// File: rtl/cart_prg_banker.sv
module cart_prg_banker
   import cart_pkg::*;
#(
   parameter int ADDR_W        = 16,
   parameter int DATA_W        = 8,
   parameter int LOW_W         = 4,
   parameter int HIGH_W        = 2,
   parameter bit SWAP_ON_CLEAR = 1'b1,
   localparam int BANK_W       = LOW_W + HIGH_W,
   localparam int REG_W        = (LOW_W > 3) ? LOW_W : 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_data,
   input  logic              cpu_rw,
   input  logic              cpu_m2,
   output logic [BANK_W-1:0] prg_bank,
   output logic              rom_ce_n,
   output logic              ram_ce_n,
   output logic              ram_oe_n,
   output logic              ram_we_n
);

   generate
      if (REG_W > DATA_W) begin : g_bad_data
         $error("cart_prg_banker: DATA_W too narrow for the bank registers");
      end
   endgenerate

   logic              wr_stb;
   reg_sel_e          sel;
   logic [LOW_W-1:0]  low_q;
   logic [HIGH_W-1:0] high_q;
   mode_t             mode_q;

   cart_wr_decode #(.ADDR_W(ADDR_W)) u_dec (
      .clk    (clk),
      .rst_n  (rst_n),
      .addr   (cpu_addr),
      .rw     (cpu_rw),
      .m2     (cpu_m2),
      .wr_stb (wr_stb),
      .sel    (sel)
   );

   cart_bank_regs #(.LOW_W(LOW_W), .HIGH_W(HIGH_W), .SWAP_ON_CLEAR(SWAP_ON_CLEAR)) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_stb (wr_stb),
      .sel    (sel),
      .data   (cpu_data[REG_W-1:0]),
      .low_q  (low_q),
      .high_q (high_q),
      .mode_q (mode_q)
   );

   cart_mem_map #(.LOW_W(LOW_W), .HIGH_W(HIGH_W)) u_map (
      .low_q    (low_q),
      .high_q   (high_q),
      .mode_q   (mode_q),
      .addr_top (cpu_addr[ADDR_W-1:ADDR_W-3]),
      .rw       (cpu_rw),
      .m2       (cpu_m2),
      .prg_bank (prg_bank),
      .rom_ce_n (rom_ce_n),
      .ram_ce_n (ram_ce_n),
      .ram_oe_n (ram_oe_n),
      .ram_we_n (ram_we_n)
   );

   AST_BOOT_BANK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (prg_bank[1:0] == 2'b11 && prg_bank[BANK_W-1:2] == '0))
      else $error("AST_BOOT_BANK");  // R1

   AST_FORCE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_q.pass_low |-> prg_bank[1:0] == 2'b11)
      else $error("AST_FORCE_HIGH");  // R6

   AST_ROM_RAM_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(!rom_ce_n && !ram_ce_n))
      else $error("AST_ROM_RAM_EXCL");  // R9

   AST_WE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !ram_we_n |-> (!cpu_rw && !ram_ce_n && ram_oe_n))
      else $error("AST_WE_ON_WRITE");  // R10

endmodule

// File: tb/tb_cart_prg_banker.sv
`timescale 1ns/1ps
module tb_cart_prg_banker;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cpu_addr = 16'h0000;
   logic [7:0]  cpu_data = 8'h00;
   logic        cpu_rw = 1'b1;
   logic        cpu_m2 = 1'b0;
   logic [5:0]  prg_bank;
   logic        rom_ce_n, ram_ce_n, ram_oe_n, ram_we_n;

   int n_checks = 0;
   int n_fail   = 0;
   int cycles   = 0;
   bit done     = 1'b0;

   always #2.5 clk = ~clk;

   cart_prg_banker dut (
      .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
      .cpu_rw(cpu_rw), .cpu_m2(cpu_m2), .prg_bank(prg_bank),
      .rom_ce_n(rom_ce_n), .ram_ce_n(ram_ce_n), .ram_oe_n(ram_oe_n), .ram_we_n(ram_we_n)
   );

   task automatic report();
      $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000 && !done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual %0d cycles, expected fewer", cycles);
         report();
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic bus_cycle(input logic [15:0] a, input logic [7:0] d, input logic rw);
      @(negedge clk);
      cpu_addr = a; cpu_data = d; cpu_rw = rw; cpu_m2 = 1'b1;
      repeat (2) @(negedge clk);
      cpu_m2 = 1'b0;
      repeat (2) @(negedge clk);
      cpu_rw = 1'b1;
   endtask

   function automatic logic [3:0] xchg(input logic [3:0] v, input logic keep);
      return keep ? v : {v[3:2], v[0], v[1]};
   endfunction

   function automatic logic [5:0] exp_bank(input logic [3:0] lo, input logic [1:0] hi, input logic pass);
      return {hi, lo[3:2], pass ? lo[1:0] : 2'b11};
   endfunction

   initial begin
      logic [5:0] held;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(prg_bank == 6'b000011, "R1 boot bank 3", prg_bank, 6'b000011);

      // Sweep: mode then low then high, back to back
      for (int m = 0; m < 8; m++) begin
         for (int lo = 0; lo < 16; lo++) begin
            for (int hi = 0; hi < 4; hi++) begin
               logic [3:0] lo_e;
               logic [3:0] hi_e;
               logic [5:0] e;
               bus_cycle(16'h5300 | 16'(lo), 8'(m) | 8'hF8, 1'b0);
               bus_cycle(16'h5000 | 16'(hi * 16), 8'(lo) | 8'hA0, 1'b0);
               bus_cycle(((hi & 1) != 0) ? 16'h5577 : 16'h5100, 8'(hi) | 8'h50, 1'b0);
               lo_e = xchg(4'(lo), m[0]);
               hi_e = xchg(4'(hi), m[0]);
               e = exp_bank(lo_e, hi_e[1:0], m[2]);
               @(negedge clk);
               chk(prg_bank == e, "R2 R3 R4 R5 R6 sweep", prg_bank, e);
            end
         end
      end

      // R7: exchange bit changes after a load, held value stays
      bus_cycle(16'h5300, 8'h05, 1'b0);
      bus_cycle(16'h5000, 8'h09, 1'b0);
      bus_cycle(16'h5100, 8'h02, 1'b0);
      @(negedge clk);
      chk(prg_bank == 6'b101001, "R2 straight load", prg_bank, 6'b101001);
      bus_cycle(16'h5300, 8'h04, 1'b0);
      @(negedge clk);
      chk(prg_bank == 6'b101001, "R7 mode rewrite keeps banks", prg_bank, 6'b101001);
      bus_cycle(16'h5300, 8'h00, 1'b0);
      @(negedge clk);
      chk(prg_bank == 6'b101011, "R6 forced high after mode clear", prg_bank, 6'b101011);
      bus_cycle(16'h5300, 8'h04, 1'b0);
      @(negedge clk);
      chk(prg_bank == 6'b101001, "R7 low bits survive forcing", prg_bank, 6'b101001);

      // R8: reads and foreign addresses leave state alone
      held = prg_bank;
      bus_cycle(16'h5000, 8'h06, 1'b1);
      bus_cycle(16'h5100, 8'h01, 1'b1);
      bus_cycle(16'h5300, 8'h01, 1'b1);
      @(negedge clk);
      chk(prg_bank == held, "R8 read cycles ignored", prg_bank, held);
      bus_cycle(16'h5200, 8'h0F, 1'b0);
      bus_cycle(16'h5400, 8'h0F, 1'b0);
      bus_cycle(16'h4000, 8'h0F, 1'b0);
      bus_cycle(16'h8000, 8'h0F, 1'b0);
      @(negedge clk);
      chk(prg_bank == held, "R8 foreign writes ignored", prg_bank, held);
      // R8: write with M2 never falling has no effect
      @(negedge clk);
      cpu_addr = 16'h5000; cpu_data = 8'h03; cpu_rw = 1'b0; cpu_m2 = 1'b1;
      repeat (4) @(negedge clk);
      chk(prg_bank == held, "R8 no capture before M2 fall", prg_bank, held);
      cpu_rw = 1'b1;
      repeat (2) @(negedge clk);
      cpu_m2 = 1'b0;
      repeat (2) @(negedge clk);
      chk(prg_bank == held, "R8 M2 fall in read ignored", prg_bank, held);

      // R9 R10: address decode sweep
      for (int t = 0; t < 8; t++) begin
         for (int r = 0; r < 2; r++) begin
            for (int q = 0; q < 2; q++) begin
               logic rhit;
               @(negedge clk);
               cpu_addr = 16'(t * 16'h2000) | 16'h0123;
               cpu_rw = r[0]; cpu_m2 = q[0];
               #1;
               rhit = (t == 3);
               chk(rom_ce_n == !(t >= 4 && r == 1), "R9 rom enable", rom_ce_n, !(t >= 4 && r == 1));
               chk(ram_ce_n == !(rhit && q == 1), "R10 ram ce", ram_ce_n, !(rhit && q == 1));
               chk(ram_oe_n == !(rhit && q == 1 && r == 1), "R10 ram oe", ram_oe_n, !(rhit && q == 1 && r == 1));
               chk(ram_we_n == !(rhit && q == 1 && r == 0), "R10 ram we", ram_we_n, !(rhit && q == 1 && r == 0));
            end
         end
      end
      @(negedge clk);
      cpu_m2 = 1'b0; cpu_rw = 1'b1;

      // R1: reset again clears to bank 3
      bus_cycle(16'h5000, 8'h00, 1'b0);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(prg_bank == 6'b000011, "R1 second reset", prg_bank, 6'b000011);

      done = 1'b1;
      report();
   end

endmodule